// File: doc/BRIEF.md
# Debug command word parser

This block sits between the word-level side of a serial debug port and the logic that performs register and memory accesses for the host. It receives 16-bit words over a valid/ready handshake. Each command starts with an operation word. The block decodes that word, works out how many extension words follow, and gathers them into a 32-bit absolute address and a 32-bit operand. It forces alignment on sized memory addresses and then issues one decoded command record with a single-cycle strobe.

After the strobe the block stops taking input until the access side acknowledges. For read commands, the acknowledge carries 32 bits of data. The block cuts this data into one or two 16-bit response words, sent most-significant word first over a second valid/ready handshake. A malformed operation word is answered with a single error word. No command is issued for it and no extension words are taken.

Top module: `dbg_cmd_parser`

## Requirements
- R1: The operation word is decoded as follows. Bits 15:10 select the command: 000000 is no-op, 000010 is register access and 000101 is memory access. Bit 8 is the direction, where 1 means read toward the host and 0 means write from the host. Bits 7:6 are the size (00 byte, 01 word, 10 longword). Bit 3 selects an address register (1) or a data register (0). Bits 2:0 are the register number. The record shows these fields as `cmd_kind` (0 no-op, 1 register, 2 memory), `cmd_write` (the inverse of bit 8), `cmd_areg` and `cmd_regnum`.
- R2: A word is illegal if any of bit 9, bit 5 or bit 4 is set, if the size is 11, or if the opcode is undefined. An illegal word produces no `cmd_valid`, takes no extension words and returns exactly one response word equal to `ERR_WORD` (default 16'hFFFF). The next input word is decoded as a new operation word.
- R3: The number of extension words after the operation word depends on the command. A no-op and a register read take none. A register write takes 2 and a memory read takes 2. A memory write takes 3 for byte or word size and 4 for longword size.
- R4: For memory commands, the first two extension words form the address, with the upper half first. Data words follow, with the upper half first when there are two.
- R5: For longword memory commands, `cmd_addr` has bits 1:0 cleared. For word memory commands, bit 0 is cleared. For byte commands the address is passed unchanged.
- R6: `cmd_data` for a write depends on the size. A byte write gives the low 8 bits of the data word, zero-extended. A word write gives the 16-bit word, zero-extended. A longword write and any register write give the full 32 bits.
- R7: `cmd_valid` is high for exactly one cycle, in the cycle after the last expected word is accepted. `in_ready` stays low from that cycle until `ack_valid` is seen. An acknowledge is accepted in the strobe cycle or in any later cycle.
- R8: Memory and register reads answer after the acknowledge. A byte read returns {8'h00, data[7:0]} and a word read returns data[15:0]. A longword read returns data[31:16] and then data[15:0]. Register commands always report `cmd_size` = 10 and always answer a read with two words. Writes and no-ops produce no response.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_word` holds its value. `in_ready` stays low until the last response word is taken.
- R10: After reset, `in_ready` is 1 and both `cmd_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word offered |
| in_word | input | 16 | Operation or extension word |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_kind | output | 2 | 0 no-op, 1 register, 2 memory |
| cmd_write | output | 1 | 1 for a transfer from the host |
| cmd_size | output | 2 | Access size; register commands report longword |
| cmd_areg | output | 1 | Address-register select |
| cmd_regnum | output | 3 | Register number |
| cmd_addr | output | 32 | Aligned absolute memory address |
| cmd_data | output | 32 | Write operand, zero-extended to size |
| ack_valid | input | 1 | Access side finished the command |
| ack_data | input | 32 | Read data returned with the acknowledge |
| rsp_valid | output | 1 | Response word offered |
| rsp_word | output | 16 | Response word |
| rsp_ready | input | 1 | Host side takes the response word |

## Verification
Two events can fall in the same cycle: the command strobe and the acknowledge that finishes it. The bench provokes this on alternate commands by raising `ack_valid` in the very cycle `cmd_valid` is first seen. It then expects the strobe gone and the first response word present one cycle later, exactly as when the acknowledge comes late. A second overlap is an input word held valid while the parser is stalled. That word must wait through the stall and then be decoded as the next operation.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

    localparam int WORD_W = 16;
    localparam int LONG_W = 2 * WORD_W;

    localparam logic [5:0] OPC_NOP = 6'h00;
    localparam logic [5:0] OPC_REG = 6'h02;
    localparam logic [5:0] OPC_MEM = 6'h05;

    typedef enum logic [1:0] {
        K_NOP = 2'd0,
        K_REG = 2'd1,
        K_MEM = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        F_ERR  = 2'd0,
        F_BYTE = 2'd1,
        F_WORD = 2'd2,
        F_LONG = 2'd3
    } fmt_e;

    typedef struct packed {
        kind_e      kind;
        logic       write;
        size_e      size;
        logic       areg;
        logic [2:0] regnum;
        logic [2:0] n_addr;
        logic [2:0] n_ext;
        logic       illegal;
    } op_dec_t;

    function automatic logic [LONG_W-1:0] align_addr(input logic [LONG_W-1:0] a, input size_e s);
        case (s)
            SZ_LONG: return {a[LONG_W-1:2], 2'b00};
            SZ_WORD: return {a[LONG_W-1:1], 1'b0};
            default: return a;
        endcase
    endfunction

    function automatic logic [LONG_W-1:0] fit_data(input logic [LONG_W-1:0] d, input size_e s);
        case (s)
            SZ_BYTE: return {{(LONG_W-8){1'b0}}, d[7:0]};
            SZ_WORD: return {{(LONG_W-WORD_W){1'b0}}, d[WORD_W-1:0]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/dbgp_decode.sv
module dbgp_decode
    import dbgp_pkg::*;
(
    input  logic [WORD_W-1:0] op_word,
    output op_dec_t           dec
);

    logic rsvd_set;
    logic known;

    always_comb begin
        dec        = '0;
        known      = 1'b0;
        rsvd_set   = op_word[9] | op_word[5] | op_word[4];
        dec.write  = ~op_word[8];
        dec.size   = size_e'(op_word[7:6]);
        dec.areg   = op_word[3];
        dec.regnum = op_word[2:0];
        case (op_word[15:10])
            OPC_NOP: begin
                known    = 1'b1;
                dec.kind = K_NOP;
            end
            OPC_REG: begin
                known     = 1'b1;
                dec.kind  = K_REG;
                dec.size  = SZ_LONG;
                dec.n_ext = dec.write ? 3'd2 : 3'd0;
            end
            OPC_MEM: begin
                known      = 1'b1;
                dec.kind   = K_MEM;
                dec.n_addr = 3'd2;
                if (!dec.write)
                    dec.n_ext = 3'd2;
                else if (op_word[7:6] == 2'b10)
                    dec.n_ext = 3'd4;
                else
                    dec.n_ext = 3'd3;
            end
            default: known = 1'b0;
        endcase
        dec.illegal = rsvd_set | (op_word[7:6] == 2'b11) | ~known;
        if (dec.illegal) begin
            dec.n_ext  = 3'd0;
            dec.n_addr = 3'd0;
        end
    end

endmodule

// File: rtl/dbgp_rsp_fmt.sv
module dbgp_rsp_fmt
    import dbgp_pkg::*;
#(
    parameter logic [WORD_W-1:0] ERR_WORD = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  fmt_e              mode,
    input  logic [LONG_W-1:0] data,
    input  logic              rsp_ready,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_word,
    output logic              rsp_last
);

    logic [LONG_W-1:0] shift_q;
    logic [1:0]        left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            left_q  <= 2'd0;
        end else if (load) begin
            case (mode)
                F_ERR: begin
                    shift_q <= {ERR_WORD, {WORD_W{1'b0}}};
                    left_q  <= 2'd1;
                end
                F_BYTE: begin
                    shift_q <= {8'h00, data[7:0], {WORD_W{1'b0}}};
                    left_q  <= 2'd1;
                end
                F_WORD: begin
                    shift_q <= {data[WORD_W-1:0], {WORD_W{1'b0}}};
                    left_q  <= 2'd1;
                end
                default: begin
                    shift_q <= data;
                    left_q  <= 2'd2;
                end
            endcase
        end else if (left_q != 2'd0 && rsp_ready) begin
            shift_q <= {shift_q[WORD_W-1:0], {WORD_W{1'b0}}};
            left_q  <= left_q - 2'd1;
        end
    end

    assign rsp_valid = (left_q != 2'd0);
    assign rsp_word  = shift_q[LONG_W-1:WORD_W];
    assign rsp_last  = (left_q == 2'd1);

    a_r9_word_held: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready && !load) |=> (rsp_valid && $stable(rsp_word)));

endmodule

// File: rtl/dbg_cmd_parser.sv
module dbg_cmd_parser
    import dbgp_pkg::*;
#(
    parameter logic [WORD_W-1:0] ERR_WORD = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic              cmd_write,
    output logic [1:0]        cmd_size,
    output logic              cmd_areg,
    output logic [2:0]        cmd_regnum,
    output logic [LONG_W-1:0] cmd_addr,
    output logic [LONG_W-1:0] cmd_data,
    input  logic              ack_valid,
    input  logic [LONG_W-1:0] ack_data,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_word,
    input  logic              rsp_ready
);

    typedef enum logic [2:0] {
        ST_OP    = 3'd0,
        ST_EXT   = 3'd1,
        ST_ISSUE = 3'd2,
        ST_WAIT  = 3'd3,
        ST_RSP   = 3'd4
    } state_e;

    state_e            st_q;
    op_dec_t           dec;
    op_dec_t           rec;
    logic [LONG_W-1:0] addr_q;
    logic [LONG_W-1:0] data_q;
    logic [2:0]        ext_idx;
    logic              rd_cmd;
    logic              fmt_load;
    fmt_e              fmt_mode;
    logic              rsp_last;

    dbgp_decode u_decode (
        .op_word (in_word),
        .dec     (dec)
    );

    assign rd_cmd = !rec.write && (rec.kind != K_NOP);

    always_comb begin
        fmt_load = 1'b0;
        fmt_mode = F_ERR;
        if (st_q == ST_OP) begin
            fmt_load = in_valid && dec.illegal;
        end else begin
            fmt_load = (st_q == ST_ISSUE || st_q == ST_WAIT) && ack_valid && rd_cmd;
            case (rec.size)
                SZ_BYTE: fmt_mode = F_BYTE;
                SZ_WORD: fmt_mode = F_WORD;
                default: fmt_mode = F_LONG;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_OP;
            rec     <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            ext_idx <= 3'd0;
        end else begin
            case (st_q)
                ST_OP: if (in_valid) begin
                    rec     <= dec;
                    addr_q  <= '0;
                    data_q  <= '0;
                    ext_idx <= 3'd0;
                    if (dec.illegal)
                        st_q <= ST_RSP;
                    else if (dec.n_ext == 3'd0)
                        st_q <= ST_ISSUE;
                    else
                        st_q <= ST_EXT;
                end
                ST_EXT: if (in_valid) begin
                    if (ext_idx < rec.n_addr)
                        addr_q <= {addr_q[WORD_W-1:0], in_word};
                    else
                        data_q <= {data_q[WORD_W-1:0], in_word};
                    ext_idx <= ext_idx + 3'd1;
                    if (ext_idx == rec.n_ext - 3'd1)
                        st_q <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    if (ack_valid)
                        st_q <= rd_cmd ? ST_RSP : ST_OP;
                    else
                        st_q <= ST_WAIT;
                end
                ST_WAIT: if (ack_valid) st_q <= rd_cmd ? ST_RSP : ST_OP;
                ST_RSP: if (rsp_valid && rsp_ready && rsp_last) st_q <= ST_OP;
                default: st_q <= ST_OP;
            endcase
        end
    end

    dbgp_rsp_fmt #(.ERR_WORD(ERR_WORD)) u_rsp_fmt (
        .clk       (clk),
        .rst       (rst),
        .load      (fmt_load),
        .mode      (fmt_mode),
        .data      (ack_data),
        .rsp_ready (rsp_ready),
        .rsp_valid (rsp_valid),
        .rsp_word  (rsp_word),
        .rsp_last  (rsp_last)
    );

    assign in_ready   = (st_q == ST_OP) || (st_q == ST_EXT);
    assign cmd_valid  = (st_q == ST_ISSUE);
    assign cmd_kind   = rec.kind;
    assign cmd_write  = rec.write;
    assign cmd_size   = rec.size;
    assign cmd_areg   = rec.areg;
    assign cmd_regnum = rec.regnum;
    assign cmd_addr   = align_addr(addr_q, rec.size);
    assign cmd_data   = fit_data(data_q, rec.size);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    a_r7_input_stalled: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !in_ready);

    a_r2_error_reply: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !ext_idx[0] && st_q == ST_OP && in_valid && dec.illegal)
        |=> (rsp_valid && rsp_word == ERR_WORD && !cmd_valid));

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !rsp_valid);

    a_r9_no_input_in_reply: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !in_ready);

    a_r5_long_aligned: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd2 && cmd_size == 2'd2) |-> (cmd_addr[1:0] == 2'b00));

endmodule

// File: tb/dbg_cmd_parser_bench.sv
module dbg_cmd_parser_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        in_ready;
    logic        cmd_valid;
    logic [1:0]  cmd_kind;
    logic        cmd_write;
    logic [1:0]  cmd_size;
    logic        cmd_areg;
    logic [2:0]  cmd_regnum;
    logic [31:0] cmd_addr;
    logic [31:0] cmd_data;
    logic        ack_valid = 1'b0;
    logic [31:0] ack_data = '0;
    logic        rsp_valid;
    logic [15:0] rsp_word;
    logic        rsp_ready = 1'b0;

    localparam logic [15:0] ERR = 16'hFFFF;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dbg_cmd_parser u_dbg_cmd_parser (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_write(cmd_write), .cmd_size(cmd_size),
        .cmd_areg(cmd_areg), .cmd_regnum(cmd_regnum), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .ack_valid(ack_valid), .ack_data(ack_data), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
        .rsp_ready(rsp_ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mkop(input logic [5:0] opc, input logic dir, input logic [1:0] sz,
                                         input logic areg, input logic [2:0] rn);
        return {opc, 1'b0, dir, sz, 2'b00, areg, rn};
    endfunction

    task automatic send_word(input logic [15:0] w);
        int k;
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        k = 0;
        while (!in_ready && k < 50) begin
            @(negedge clk);
            k++;
        end
        if (!in_ready) chk("R7 input never accepted", 32'(in_ready), 32'd1);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic get_rsp(input int n, input logic [15:0] e0, input logic [15:0] e1,
                           input bit stall, input string tag);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            int k;
            logic [15:0] held;
            k = 0;
            while (!rsp_valid && k < 50) begin
                @(negedge clk);
                k++;
            end
            chk(tag, 32'(rsp_word), 32'(i == 0 ? e0 : e1));
            chk("R9 input closed during reply", 32'(in_ready), 32'd0);
            if (stall && i == 0) begin
                held = rsp_word;
                repeat (2) @(negedge clk);
                chk("R9 word held under backpressure", {15'd0, rsp_valid, rsp_word}, {15'd0, 1'b1, held});
            end
            rsp_ready = 1'b1;
            @(negedge clk);
            rsp_ready = 1'b0;
        end
        chk({tag, " reply length"}, 32'(rsp_valid), 32'd0);
        chk("R9 input reopens", 32'(in_ready), 32'd1);
    endtask

    task automatic do_cmd(input logic [15:0] op, input logic [31:0] addr, input logic [31:0] data,
                          input logic [31:0] rdata, input bit same_ack, input bit stall_rsp);
        logic [5:0]  opc;
        logic [1:0]  sz;
        bit          is_nop, is_reg, is_mem, legal, rd;
        logic [31:0] ea, ed;
        logic [15:0] w0, w1;
        opc    = op[15:10];
        sz     = op[7:6];
        rd     = op[8];
        is_nop = (opc == 6'h00);
        is_reg = (opc == 6'h02);
        is_mem = (opc == 6'h05);
        legal  = (is_nop || is_reg || is_mem) && !op[9] && op[5:4] == 2'b00 && sz != 2'b11;
        send_word(op);
        if (!legal) begin
            #1 chk("R2 no strobe for illegal word", 32'(cmd_valid), 32'd0);
            get_rsp(1, ERR, 16'h0, stall_rsp, "R2 error word");
            return;
        end
        if (is_mem) begin
            send_word(addr[31:16]);
            send_word(addr[15:0]);
        end
        if (!rd) begin
            if (is_reg || (is_mem && sz == 2'b10)) begin
                send_word(data[31:16]);
                send_word(data[15:0]);
            end else if (is_mem) begin
                send_word(data[15:0]);
            end
        end
        @(negedge clk);
        chk("R3 strobe right after last word", 32'(cmd_valid), 32'd1);
        while (!cmd_valid) @(negedge clk);
        chk("R1 kind", 32'(cmd_kind), is_nop ? 32'd0 : (is_reg ? 32'd1 : 32'd2));
        if (!is_nop) begin
            chk("R1 direction", 32'(cmd_write), 32'(!rd));
            chk("R1 register select", {28'd0, cmd_areg, cmd_regnum}, {28'd0, op[3], op[2:0]});
        end
        if (is_reg) chk("R8 register size forced long", 32'(cmd_size), 32'd2);
        if (is_mem) begin
            case (sz)
                2'b10:   ea = {addr[31:2], 2'b00};
                2'b01:   ea = {addr[31:1], 1'b0};
                default: ea = addr;
            endcase
            chk("R4 R5 address", cmd_addr, ea);
        end
        if (!rd && !is_nop) begin
            if (is_reg || sz == 2'b10) ed = data;
            else if (sz == 2'b01)      ed = {16'h0, data[15:0]};
            else                       ed = {24'h0, data[7:0]};
            chk("R4 R6 write data", cmd_data, ed);
        end
        chk("R7 input stalled at strobe", 32'(in_ready), 32'd0);
        if (same_ack) begin
            ack_valid = 1'b1;
            ack_data  = rdata;
            @(negedge clk);
            ack_valid = 1'b0;
            chk("R7 strobe one cycle", 32'(cmd_valid), 32'd0);
        end else begin
            @(negedge clk);
            chk("R7 strobe one cycle", 32'(cmd_valid), 32'd0);
            chk("R7 input stalled before ack", 32'(in_ready), 32'd0);
            repeat (2) @(negedge clk);
            ack_valid = 1'b1;
            ack_data  = rdata;
            @(negedge clk);
            ack_valid = 1'b0;
        end
        if (rd && !is_nop) begin
            if (is_reg || sz == 2'b10) begin
                w0 = rdata[31:16];
                w1 = rdata[15:0];
                get_rsp(2, w0, w1, stall_rsp, "R8 long reply");
            end else if (sz == 2'b01) begin
                get_rsp(1, rdata[15:0], 16'h0, stall_rsp, "R8 word reply");
            end else begin
                get_rsp(1, {8'h00, rdata[7:0]}, 16'h0, stall_rsp, "R8 byte reply");
            end
        end else begin
            chk("R8 no reply for write or no-op", 32'(rsp_valid), 32'd0);
            chk("R3 back to operation word", 32'(in_ready), 32'd1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int idx;
        logic [31:0] rd_pat;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R10 ready after reset", 32'(in_ready), 32'd1);
        chk("R10 no strobe after reset", 32'(cmd_valid), 32'd0);
        chk("R10 no reply after reset", 32'(rsp_valid), 32'd0);

        idx = 0;
        do_cmd(mkop(6'h00, 1'b0, 2'b00, 1'b0, 3'd0), 32'h0, 32'h0, 32'h0, 1'b0, 1'b0);
        do_cmd(mkop(6'h00, 1'b1, 2'b01, 1'b0, 3'd0), 32'h0, 32'h0, 32'h0, 1'b1, 1'b0);

        for (int a = 0; a < 2; a++)
            for (int r = 0; r < 8; r++)
                for (int d = 0; d < 2; d++) begin
                    idx++;
                    rd_pat = 32'hC0DE_1357 + idx * 32'h0101_0117;
                    do_cmd(mkop(6'h02, d[0], 2'(r % 3), a[0], r[2:0]), 32'h0,
                           32'h8765_4321 ^ (idx * 32'h0011_2233), rd_pat, idx[0], (idx % 5) == 0);
                end

        for (int s = 0; s < 3; s++)
            for (int lo = 0; lo < 4; lo++)
                for (int d = 0; d < 2; d++) begin
                    idx++;
                    rd_pat = 32'hA5C3_5A3C + idx * 32'h0103_0507;
                    do_cmd(mkop(6'h05, d[0], s[1:0], 1'b0, 3'd0), {28'h1234_567, 2'b10, lo[1:0]},
                           32'hF00D_BEEF ^ (idx * 32'h0301_0401), rd_pat, idx[0], (idx % 3) == 0);
                end

        for (int o = 0; o < 64; o++) begin
            if (o != 0 && o != 2 && o != 5)
                do_cmd(mkop(o[5:0], o[0], 2'b01, 1'b0, 3'd1), 32'h0, 32'h0, 32'h0, 1'b0, o == 7);
        end
        do_cmd(mkop(6'h02, 1'b1, 2'b10, 1'b0, 3'd0) | 16'h0200, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0);
        do_cmd(mkop(6'h05, 1'b0, 2'b01, 1'b0, 3'd0) | 16'h0010, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0);
        do_cmd(mkop(6'h00, 1'b0, 2'b00, 1'b0, 3'd0) | 16'h0020, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0);
        do_cmd(mkop(6'h05, 1'b1, 2'b11, 1'b0, 3'd0), 32'h0, 32'h0, 32'h0, 1'b0, 1'b0);
        do_cmd(mkop(6'h02, 1'b1, 2'b11, 1'b1, 3'd4), 32'h0, 32'h0, 32'h0, 1'b0, 1'b0);
        do_cmd(mkop(6'h05, 1'b1, 2'b00, 1'b0, 3'd0), 32'h0000_1003, 32'h0, 32'h0000_00E7, 1'b0, 1'b0);

        send_word(mkop(6'h02, 1'b0, 2'b10, 1'b1, 3'd6));
        send_word(16'h1111);
        send_word(16'h2222);
        @(negedge clk);
        chk("R7 strobe before held input", 32'(cmd_valid), 32'd1);
        in_valid = 1'b1;
        in_word  = mkop(6'h00, 1'b0, 2'b00, 1'b0, 3'd0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R7 held input not taken while waiting", 32'(in_ready), 32'd0);
        end
        chk("R7 record held while waiting", cmd_data, 32'h1111_2222);
        ack_valid = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0;
        chk("R7 input reopens after ack", 32'(in_ready), 32'd1);
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        chk("R7 held word decoded as operation", {29'd0, cmd_valid, cmd_kind}, {29'd0, 1'b1, 2'd0});
        ack_valid = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0;
        chk("R8 no reply after no-op", 32'(rsp_valid), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule